// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Code Register Front End

This block is the digital register front end of a multi-channel digital-to-analog converter. A host reaches it over a small parallel bus. The bus has an active-low chip select, a direction bit, a channel address, a write data bus and a read data bus with an output enable. Each channel holds two registers. The staging register receives host writes. The output register supplies the code that the converter sees.

A single active-low load input is shared by all channels. The load is level-sensitive. While it is low, every output register tracks its staging register, so the pair is transparent. A short low pulse moves all staged values to the outputs on the same clock edge. The host can therefore stage new codes on every channel and then switch them all at once.

An asynchronous active-low reset presets every register to zero code or to midscale. A strap input chooses between the two, and only its value during reset matters. The resolution and the channel count are parameters. Midscale is the code with only the top bit set, for example 0x800 at 12 bits and 0x200 at 10 bits.

Top module: `qdac_front`

## Requirements
- R1: While reset is low with the strap low, every staging register and every output register reads zero code.
- R2: While reset is low with the strap high, every register reads midscale, 1 << (RES_W-1) (0x800 at 12 bits, 0x200 at 10 bits).
- R3: A write is committed at the first clock edge that samples chip select high after it was low, when the direction bit was 0 (write) during the low phase. The last address and data sampled during that phase go into the addressed staging register. No register is written while chip select is low.
- R4: At every clock edge that samples load low, all output registers take the staging register values being formed on that edge, on all channels together.
- R5: A write committed while load is low reaches the addressed output register on the same edge as its staging register.
- R6: At an edge that samples load high, no output register changes, even when a staging register is written.
- R7: While chip select is low with the direction bit 1 (read), the output enable is high and the read bus shows the addressed staging register without a clock delay. At all other times the output enable is low and the read bus is zero.
- R8: A change of the strap after reset is released alters no register until the next reset.
- R9: A read cycle leaves every staging and output register unchanged.
- R10: Channel n's output code appears on dac_codes bits [n*RES_W +: RES_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mid_sel | input | 1 | Reset preset strap: 0 gives zero code, 1 gives midscale |
| cs_n | input | 1 | Chip select, active low; the rising edge commits a write |
| rd_wr | input | 1 | Direction bit: 1 for read, 0 for write |
| addr | input | AW | Channel address |
| data_in | input | RES_W | Write data |
| data_out | output | RES_W | Read data (zero when not driven) |
| data_oe | output | 1 | High while the read data is valid and should be driven onto the pad |
| ld_n | input | 1 | Common level-sensitive load, active low |
| dac_codes | output | NCH*RES_W | Output register codes, with channel 0 in the low bits |

## Verification
A table of writes stresses the double buffering. Some writes are made with load held high, so the staged value and the output must differ afterwards. Others are made with load held low, so the addressed output and all other channels must change together. A bare load pulse after several staged writes separates a simultaneous update from a per-channel update. Reset is applied with each strap value, and the strap is then toggled without a reset, which tells a sampled preset apart from a live one. A second instance at 10-bit resolution shows that the midscale preset scales with the width.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   typedef enum logic {
      BUS_WR = 1'b0,
      BUS_RD = 1'b1
   } bus_dir_e;

   // preset code for a register of width w: midscale or zero
   function automatic int unsigned preset_code(int w, logic mid);
      return mid ? (32'd1 << (w - 1)) : 32'd0;
   endfunction

endpackage

// File: rtl/qdac_bus.sv
module qdac_bus
   import qdac_pkg::*;
#(
   parameter int NCH = 4,
   parameter int W   = 12,
   localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             rd_wr,
   input  logic [AW-1:0]    addr,
   input  logic [W-1:0]     data_in,
   input  logic [NCH*W-1:0] in_flat,
   output logic [NCH-1:0]   wr_en,
   output logic [W-1:0]     wr_data,
   output logic [W-1:0]     data_out,
   output logic             data_oe
);

   logic          cs_q;
   bus_dir_e      dir_q;
   logic [AW-1:0] addr_q;
   logic [W-1:0]  data_q;
   logic          wr_fire;

   // capture bus fields during the select-low phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         dir_q  <= BUS_RD;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         cs_q <= cs_n;
         if (!cs_n) begin
            dir_q  <= bus_dir_e'(rd_wr);
            addr_q <= addr;
            data_q <= data_in;
         end
      end
   end

   assign wr_fire = cs_n && !cs_q && (dir_q == BUS_WR);
   assign wr_data = data_q;

   for (genvar gi = 0; gi < NCH; gi++) begin : g_dec
      assign wr_en[gi] = wr_fire && (addr_q == AW'(gi));
   end

   always_comb begin
      data_oe  = !cs_n && (bus_dir_e'(rd_wr) == BUS_RD);
      data_out = '0;
      if (data_oe) data_out = in_flat[int'(addr)*W +: W];
   end

endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] preset,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         ld_act,
   output logic [W-1:0] in_q,
   output logic [W-1:0] dac_q
);

   logic [W-1:0] in_nxt;

   assign in_nxt = wr_en ? wr_data : in_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= preset;
         dac_q <= preset;
      end else begin
         in_q <= in_nxt;
         if (ld_act) dac_q <= in_nxt;
      end
   end

endmodule

// File: rtl/qdac_front.sv
module qdac_front
   import qdac_pkg::*;
#(
   parameter int NCH   = 4,
   parameter int RES_W = 12,
   localparam int AW   = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mid_sel,
   input  logic                 cs_n,
   input  logic                 rd_wr,
   input  logic [AW-1:0]        addr,
   input  logic [RES_W-1:0]     data_in,
   output logic [RES_W-1:0]     data_out,
   output logic                 data_oe,
   input  logic                 ld_n,
   output logic [NCH*RES_W-1:0] dac_codes
);

   if (RES_W < 2 || RES_W > 16) begin : g_bad_width
      $error("qdac_front: RES_W must lie in 2..16");
   end
   if (NCH < 1 || NCH > 16) begin : g_bad_count
      $error("qdac_front: NCH must lie in 1..16");
   end

   logic [RES_W-1:0]     preset;
   logic [NCH-1:0]       wr_en;
   logic [RES_W-1:0]     wr_data;
   logic [NCH*RES_W-1:0] in_flat;

   // the strap only matters while reset is asserted
   assign preset = RES_W'(preset_code(RES_W, mid_sel));

   qdac_bus #(.NCH(NCH), .W(RES_W)) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .rd_wr   (rd_wr),
      .addr    (addr),
      .data_in (data_in),
      .in_flat (in_flat),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .data_out(data_out),
      .data_oe (data_oe)
   );

   for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
      qdac_chan #(.W(RES_W)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .preset (preset),
         .wr_en  (wr_en[gc]),
         .wr_data(wr_data),
         .ld_act (!ld_n),
         .in_q   (in_flat[gc*RES_W +: RES_W]),
         .dac_q  (dac_codes[gc*RES_W +: RES_W])
      );
   end

endmodule

// File: rtl/qdac_chk.sv
module qdac_chk #(
   parameter int NCH = 4,
   parameter int W   = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             rd_wr,
   input logic             ld_n,
   input logic [W-1:0]     data_out,
   input logic             data_oe,
   input logic [NCH*W-1:0] dac_codes,
   input logic [NCH*W-1:0] in_flat
);

   // R6: outputs hold at an edge that samples load high
   a_r6_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ld_n |=> $stable(dac_codes));

   // R4: outputs equal staged values after an edge that samples load low
   a_r4_dac_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_n |=> (dac_codes == in_flat));

   // R3: nothing is written while chip select is low
   a_r3_no_commit_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |=> $stable(in_flat));

   // R9: closing a read cycle writes nothing
   a_r9_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && !$past(cs_n) && $past(rd_wr)) |=> $stable(in_flat));

   // R7: the read bus is zero whenever it is not enabled
   a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !data_oe |-> (data_out == '0));

   // R7: no read drive while deselected
   a_r7_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !data_oe);

endmodule

bind qdac_front qdac_chk #(.NCH(NCH), .W(RES_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .rd_wr    (rd_wr),
   .ld_n     (ld_n),
   .data_out (data_out),
   .data_oe  (data_oe),
   .dac_codes(dac_codes),
   .in_flat  (in_flat)
);

// File: tb/test_qdac_front.sv
module test_qdac_front;

   localparam int NCH = 4;
   localparam int W   = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mid_sel = 1'b0;
   logic          cs_n = 1'b1;
   logic          rd_wr = 1'b1;
   logic [1:0]    addr = '0;
   logic [W-1:0]  data_in = '0;
   logic [W-1:0]  data_out;
   logic          data_oe;
   logic          ld_n = 1'b1;
   logic [NCH*W-1:0] dac_codes;

   logic [9:0]    d10_out;
   logic          d10_oe;
   logic [39:0]   d10_codes;

   int n_chk = 0;
   int n_bad = 0;
   logic [W-1:0] exp_in  [NCH];
   logic [W-1:0] exp_dac [NCH];

   always #10 clk = ~clk;

   qdac_front #(.NCH(NCH), .RES_W(W)) i_qdac_front (
      .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel), .cs_n(cs_n),
      .rd_wr(rd_wr), .addr(addr), .data_in(data_in),
      .data_out(data_out), .data_oe(data_oe), .ld_n(ld_n),
      .dac_codes(dac_codes)
   );

   qdac_front #(.NCH(4), .RES_W(10)) i_qdac_front_r10 (
      .clk(clk), .rst_n(rst_n), .mid_sel(1'b1), .cs_n(1'b1),
      .rd_wr(1'b1), .addr(2'd0), .data_in(10'd0),
      .data_out(d10_out), .data_oe(d10_oe), .ld_n(1'b1),
      .dac_codes(d10_codes)
   );

   // one row per write: {load low during write, channel, data}
   localparam logic [14:0] VEC [8] = '{
      {1'b0, 2'd0, 12'h123},
      {1'b0, 2'd1, 12'hABC},
      {1'b1, 2'd2, 12'hFFF},
      {1'b0, 2'd3, 12'h001},
      {1'b0, 2'd2, 12'h555},
      {1'b1, 2'd3, 12'h7FF},
      {1'b0, 2'd0, 12'h000},
      {1'b1, 2'd1, 12'h800}
   };

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_all_dac(string req);
      for (int i = 0; i < NCH; i++) chk(req, dac_codes[i*W +: W], exp_dac[i]);
   endtask

   task automatic bus_write(logic [1:0] ch, logic [W-1:0] val, bit ld);
      @(negedge clk);
      ld_n = !ld; cs_n = 1'b0; rd_wr = 1'b0; addr = ch; data_in = val;
      @(negedge clk);
      cs_n = 1'b1;
      @(negedge clk);           // commit edge has passed
      ld_n = 1'b1;
      exp_in[ch] = val;
      if (ld) for (int i = 0; i < NCH; i++) exp_dac[i] = exp_in[i];
   endtask

   task automatic bus_read(logic [1:0] ch, string req);
      @(negedge clk);
      cs_n = 1'b0; rd_wr = 1'b1; addr = ch;
      #2;
      chk(req, {11'd0, data_oe}, 12'd1);
      chk(req, data_out, exp_in[ch]);
      @(negedge clk);
      cs_n = 1'b1;
      @(negedge clk);
      chk(req, {11'd0, data_oe}, 12'd0);
      chk(req, data_out, 12'd0);
   endtask

   task automatic do_reset(logic strap);
      @(negedge clk);
      mid_sel = strap; rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
         exp_in[i]  = strap ? 12'h800 : 12'h000;
         exp_dac[i] = exp_in[i];
      end
   endtask

   initial begin : watchdog
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: strap low gives zero code
      do_reset(1'b0);
      chk_all_dac("R1");
      bus_read(2'd2, "R1");
      // R7: idle bus released
      chk("R7", {11'd0, data_oe}, 12'd0);

      // R3 R5 R6 R10: table of writes
      for (int v = 0; v < 8; v++) begin
         bus_write(VEC[v][13:12], VEC[v][11:0], VEC[v][14]);
         chk_all_dac(VEC[v][14] ? "R5" : "R6");
         bus_read(VEC[v][13:12], "R3");
      end

      // R4: stage on all channels, then one load pulse
      bus_write(2'd0, 12'h0A0, 1'b0);
      bus_write(2'd1, 12'h0B1, 1'b0);
      bus_write(2'd2, 12'h0C2, 1'b0);
      bus_write(2'd3, 12'h0D3, 1'b0);
      chk_all_dac("R6");
      @(negedge clk);
      ld_n = 1'b0;
      @(negedge clk);
      ld_n = 1'b1;
      for (int i = 0; i < NCH; i++) exp_dac[i] = exp_in[i];
      chk_all_dac("R4");
      chk("R10", dac_codes[3*W +: W], 12'h0D3);

      // R9: reads with load low change nothing
      ld_n = 1'b0;
      bus_read(2'd1, "R9");
      ld_n = 1'b1;
      chk_all_dac("R9");
      bus_read(2'd1, "R9");

      // R2: strap high gives midscale
      do_reset(1'b1);
      chk_all_dac("R2");
      bus_read(2'd0, "R2");
      for (int i = 0; i < 4; i++)
         chk("R2", {2'd0, d10_codes[i*10 +: 10]}, 12'h200);

      // R8: strap toggled without reset has no effect
      mid_sel = 1'b0;
      repeat (3) @(negedge clk);
      ld_n = 1'b0;
      @(negedge clk);
      ld_n = 1'b1;
      chk_all_dac("R8");
      bus_read(2'd3, "R8");

      // R1: next reset uses the new strap value
      do_reset(1'b0);
      chk_all_dac("R1");

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule